// File: doc/BRIEF.md
# Speculative Line Access Tracker

This block keeps two marker bits for every line of a primary data cache while the core runs speculatively past ordering points. One bit records that a retired speculative load touched the line, the other that a retired speculative store wrote it. It sits beside the cache tags. It compares incoming coherence snoops against the markers and flags an ordering violation when another agent would observe or disturb speculative state. A single-cycle commit pulse clears all markers together. A single-cycle abort pulse names every written line for invalidation and then clears all markers. Discarding those lines loses nothing, because the second-level cache still holds their committed contents.

The first speculative store to a dirty line is held back until that line has been copied to the second-level cache. A two-state controller handles this: `WB_IDLE` and `WB_WAIT`. The transition IDLE→WAIT ("wb_start") fires when a store that needs a copy arrives. The transition WAIT→IDLE fires on "wb_done" (acknowledge received) or "wb_cancel" (commit or abort). If a line carrying either marker is evicted, the block asks the core to resolve speculation, because the tracking for that line would otherwise be lost.

Top module: `spec_track`

## Requirements
- R1: After reset every read and write marker is clear and `acc_stall`, `wb_req`, `violation`, `resolve_req` and `inval_vec` are all 0.
- R2: An accepted access (`acc_valid` high, `acc_stall` low) sets the read marker of `acc_idx` for a load (`acc_is_store`=0) or its write marker for a store (`acc_is_store`=1), visible on `q_sr`/`q_sw` from the next cycle.
- R3: A snoop invalidate (`snp_valid`, `snp_is_inv`=1) to a line holding either marker raises `violation` for one cycle, starting the cycle after the snoop.
- R4: A snoop read (`snp_is_inv`=0) raises `violation` the next cycle only if the line's write marker is set. A line holding only a read marker gives no violation.
- R5: A `commit` pulse clears all markers by the next cycle.
- R6: In the cycle `abort` is high, `inval_vec` equals the set of lines whose write marker is set (bit i = line i). From the next cycle all markers are clear. `inval_vec` is 0 whenever `abort` is low.
- R7: A store to a line with `acc_dirty`=1 and write marker clear stalls, and the controller enters WB_WAIT. From the next cycle `wb_req` is high with `wb_idx` holding the line, and the stall continues until `wb_ack`. In the ack cycle `acc_stall` drops, the store is accepted and the controller returns to WB_IDLE. A dirty store to a line already marked written does not stall.
- R8: `evict_valid` on a line holding either marker raises `resolve_req` in the next cycle. An eviction of an unmarked line does not.
- R9: Commit and abort take priority over an access in the same cycle: `acc_stall` is high and no marker is set. If both pulses are high, abort behaviour applies.
- R10: A commit or abort while in WB_WAIT returns the controller to WB_IDLE, and `wb_req` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Retired speculative access present |
| acc_is_store | input | 1 | 1 = store, 0 = load |
| acc_idx | input | IDX_W | Cache line of the access |
| acc_dirty | input | 1 | Line currently dirty in the primary cache |
| acc_stall | output | 1 | Access not taken this cycle; hold it |
| wb_req | output | 1 | Request copy of line to second-level cache |
| wb_idx | output | IDX_W | Line to copy |
| wb_ack | input | 1 | Copy finished |
| snp_valid | input | 1 | External coherence request present |
| snp_is_inv | input | 1 | 1 = invalidate, 0 = read |
| snp_idx | input | IDX_W | Line hit by the request |
| violation | output | 1 | Ordering violation detected (registered) |
| evict_valid | input | 1 | A line is being replaced |
| evict_idx | input | IDX_W | Replaced line |
| resolve_req | output | 1 | Request commit or abort (registered) |
| commit | input | 1 | Flash clear of all markers |
| abort | input | 1 | Flash invalidate of written lines, then clear |
| inval_vec | output | LINES | Lines to invalidate this cycle |
| q_idx | input | IDX_W | Marker lookup index |
| q_sr | output | 1 | Read marker of `q_idx` |
| q_sw | output | 1 | Write marker of `q_idx` |

## Verification
On every cycle the assertions check that a flash leaves all markers clear, that an accepted access lands in the addressed marker, that snoops and evictions produce or withhold their one-cycle responses as the markers dictate, and that a pending copy request holds its line until acknowledged or cancelled. Some behaviours need whole sequences and are shown only by the bench's scenarios. These are the exact contents of `inval_vec` against a mix of written lines, the stall-then-accept order across a multi-cycle copy wait, the abort-over-commit priority, and the rejection of an access that collides with a flash.

// File: rtl/spec_track_pkg.sv
package spec_track_pkg;
    typedef enum logic {
        WB_IDLE = 1'b0,
        WB_WAIT = 1'b1
    } wb_state_e;
endpackage

// File: rtl/spec_bits_array.sv
module spec_bits_array #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_sr,
    input  logic             set_sw,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             flash_clr,
    output logic [LINES-1:0] sr_vec,
    output logic [LINES-1:0] sw_vec
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n || flash_clr) begin
                sr_vec[i] <= 1'b0;
                sw_vec[i] <= 1'b0;
            end else if (set_idx == IDX_W'(i)) begin
                if (set_sr) sr_vec[i] <= 1'b1;
                if (set_sw) sw_vec[i] <= 1'b1;
            end
        end
    end

    // R5
    flash_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_clr |=> (sr_vec == '0 && sw_vec == '0));
    // R2
    set_sw_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sw && !flash_clr) |=> sw_vec[$past(set_idx)]);
    // R2
    set_sr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_sr && !flash_clr) |=> sr_vec[$past(set_idx)]);
endmodule

// File: rtl/spec_wb_ctrl.sv
module spec_wb_ctrl
    import spec_track_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             need_wb,
    input  logic             wb_ack,
    input  logic             flash,
    input  logic [IDX_W-1:0] acc_idx,
    output logic             stall_wb,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);
    wb_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WB_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WB_IDLE && need_wb) idx_q <= acc_idx;
        end
    end

    always_comb begin
        state_d  = state_q;
        stall_wb = 1'b0;
        wb_req   = 1'b0;
        unique case (state_q)
            WB_IDLE: begin
                stall_wb = need_wb;
                if (need_wb && !flash) state_d = WB_WAIT;   // wb_start
            end
            WB_WAIT: begin
                wb_req   = 1'b1;
                stall_wb = !wb_ack;
                if (flash)       state_d = WB_IDLE;         // wb_cancel
                else if (wb_ack) state_d = WB_IDLE;         // wb_done
            end
            default: state_d = WB_IDLE;
        endcase
    end

    assign wb_idx = idx_q;

    // R7
    wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack && !flash) |=> (wb_req && $stable(wb_idx)));
    // R10
    wb_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash |=> !wb_req);
endmodule

// File: rtl/spec_track.sv
module spec_track #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_is_store,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic             acc_dirty,
    output logic             acc_stall,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    input  logic             wb_ack,
    input  logic             snp_valid,
    input  logic             snp_is_inv,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             violation,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_idx,
    output logic             resolve_req,
    input  logic             commit,
    input  logic             abort,
    output logic [LINES-1:0] inval_vec,
    input  logic [IDX_W-1:0] q_idx,
    output logic             q_sr,
    output logic             q_sw
);
    logic [LINES-1:0] sr_vec, sw_vec;
    logic flash, need_wb, stall_wb, accept;
    logic snp_hit, evict_hit;

    assign flash   = commit | abort;
    assign need_wb = acc_valid & acc_is_store & acc_dirty & ~sw_vec[acc_idx];

    spec_wb_ctrl #(.LINES(LINES)) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .need_wb  (need_wb),
        .wb_ack   (wb_ack),
        .flash    (flash),
        .acc_idx  (acc_idx),
        .stall_wb (stall_wb),
        .wb_req   (wb_req),
        .wb_idx   (wb_idx)
    );

    assign acc_stall = flash | stall_wb;
    assign accept    = acc_valid & ~acc_stall;

    spec_bits_array #(.LINES(LINES)) u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_sr    (accept & ~acc_is_store),
        .set_sw    (accept & acc_is_store),
        .set_idx   (acc_idx),
        .flash_clr (flash),
        .sr_vec    (sr_vec),
        .sw_vec    (sw_vec)
    );

    assign snp_hit   = snp_valid & (snp_is_inv ? (sr_vec[snp_idx] | sw_vec[snp_idx])
                                               : sw_vec[snp_idx]);
    assign evict_hit = evict_valid & (sr_vec[evict_idx] | sw_vec[evict_idx]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            violation   <= 1'b0;
            resolve_req <= 1'b0;
        end else begin
            violation   <= snp_hit;
            resolve_req <= evict_hit;
        end
    end

    assign inval_vec = abort ? sw_vec : '0;
    assign q_sr      = sr_vec[q_idx];
    assign q_sw      = sw_vec[q_idx];

    // R3
    snoop_inv_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_is_inv && (sr_vec[snp_idx] || sw_vec[snp_idx])) |=> violation);
    // R4
    snoop_rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(snp_valid && snp_is_inv) && !(snp_valid && sw_vec[snp_idx])) |=> !violation);
    // R8
    evict_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && (sr_vec[evict_idx] || sw_vec[evict_idx])) |=> resolve_req);
    // R8
    evict_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evict_valid || !(sr_vec[evict_idx] || sw_vec[evict_idx])) |=> !resolve_req);
    // R6
    abort_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (sw_vec == '0));
    // R9
    flash_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash && acc_valid) |-> acc_stall);
endmodule

// File: tb/spec_track_tb.sv
module spec_track_tb;
    localparam int PERIOD = 10;
    localparam int LINES  = 16;
    localparam int IDX_W  = $clog2(LINES);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_is_store = 0, acc_dirty = 0, wb_ack = 0;
    logic [IDX_W-1:0] acc_idx = '0, snp_idx = '0, evict_idx = '0, q_idx = '0;
    logic snp_valid = 0, snp_is_inv = 0, evict_valid = 0, commit = 0, abort = 0;
    logic acc_stall, wb_req, violation, resolve_req, q_sr, q_sw;
    logic [IDX_W-1:0] wb_idx;
    logic [LINES-1:0] inval_vec;

    always #(PERIOD/2) clk = ~clk;

    spec_track #(.LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_is_store(acc_is_store),
        .acc_idx(acc_idx), .acc_dirty(acc_dirty), .acc_stall(acc_stall),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_ack(wb_ack),
        .snp_valid(snp_valid), .snp_is_inv(snp_is_inv), .snp_idx(snp_idx),
        .violation(violation), .evict_valid(evict_valid), .evict_idx(evict_idx),
        .resolve_req(resolve_req), .commit(commit), .abort(abort),
        .inval_vec(inval_vec), .q_idx(q_idx), .q_sr(q_sr), .q_sw(q_sw)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit sr_m[LINES];
    bit sw_m[LINES];
    bit waiting_m = 0;
    int widx_m = 0;
    bit viol_m = 0, res_m = 0;
    int qsweep = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        acc_valid = 0; acc_is_store = 0; acc_dirty = 0; wb_ack = 0;
        snp_valid = 0; snp_is_inv = 0; evict_valid = 0; commit = 0; abort = 0;
    endtask

    // one clock: compare same-cycle outputs, step the model, compare registered outputs
    task automatic step();
        bit flash, need, stall, accept;
        logic [LINES-1:0] inv_e;
        q_idx = IDX_W'(qsweep % LINES);
        qsweep++;
        #1;
        flash = commit | abort;
        need = acc_valid & acc_is_store & acc_dirty & !sw_m[int'(acc_idx)];
        stall = flash | (waiting_m ? !wb_ack : need);
        accept = acc_valid & !stall;
        inv_e = '0;
        for (int i = 0; i < LINES; i++) if (abort && sw_m[i]) inv_e[i] = 1'b1;
        chk("R7/R9", "acc_stall", 32'(acc_stall), 32'(stall));
        chk("R7", "wb_req", 32'(wb_req), 32'(waiting_m));
        if (waiting_m) chk("R7", "wb_idx", 32'(wb_idx), 32'(widx_m));
        chk("R6", "inval_vec", 32'(inval_vec), 32'(inv_e));
        chk("R2", "q_sr", 32'(q_sr), 32'(sr_m[int'(q_idx)]));
        chk("R2", "q_sw", 32'(q_sw), 32'(sw_m[int'(q_idx)]));
        viol_m = snp_valid && (snp_is_inv ? (sr_m[int'(snp_idx)] | sw_m[int'(snp_idx)])
                                          : sw_m[int'(snp_idx)]);
        res_m = evict_valid && (sr_m[int'(evict_idx)] | sw_m[int'(evict_idx)]);
        @(posedge clk);
        if (flash) begin
            for (int i = 0; i < LINES; i++) begin sr_m[i] = 0; sw_m[i] = 0; end
            waiting_m = 0;
        end else begin
            if (accept && !acc_is_store) sr_m[int'(acc_idx)] = 1;
            if (accept && acc_is_store)  sw_m[int'(acc_idx)] = 1;
            if (waiting_m && wb_ack) waiting_m = 0;
            else if (!waiting_m && need) begin waiting_m = 1; widx_m = int'(acc_idx); end
        end
        @(negedge clk);
        chk("R3/R4", "violation", 32'(violation), 32'(viol_m));
        chk("R8", "resolve_req", 32'(resolve_req), 32'(res_m));
    endtask

    task automatic access(input bit st, input int idx, input bit dirty);
        clear_inputs();
        acc_valid = 1; acc_is_store = st; acc_idx = IDX_W'(idx); acc_dirty = dirty;
        step();
        clear_inputs();
    endtask

    task automatic snoop(input bit inv, input int idx);
        clear_inputs();
        snp_valid = 1; snp_is_inv = inv; snp_idx = IDX_W'(idx);
        step();
        clear_inputs();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin clear_inputs(); step(); end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin sr_m[i] = 0; sw_m[i] = 0; end
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state over a full sweep of lines
        chk("R1", "violation", 32'(violation), 0);
        chk("R1", "resolve_req", 32'(resolve_req), 0);
        idle(LINES);

        // R2: loads and clean stores at several lines
        access(0, 1, 0);
        access(0, 5, 0);
        access(1, 7, 0);
        access(1, 5, 1'b0);
        idle(2);
        // R3: invalidate hits read-only line, then written line, then unmarked line
        snoop(1, 1);
        snoop(1, 7);
        snoop(1, 9);
        // R4: read snoop to read-only line is quiet; to written line is a violation
        snoop(0, 1);
        snoop(0, 7);
        snoop(0, 5);
        // R8: evict marked and unmarked lines
        clear_inputs(); evict_valid = 1; evict_idx = 4'd1; step();
        clear_inputs(); evict_valid = 1; evict_idx = 4'd2; step();
        // R5: commit clears everything
        clear_inputs(); commit = 1; step();
        idle(LINES);

        // R7: dirty store waits three cycles for the copy acknowledge
        clear_inputs();
        acc_valid = 1; acc_is_store = 1; acc_idx = 4'd3; acc_dirty = 1;
        step(); step(); step(); step();
        wb_ack = 1; step();
        clear_inputs();
        idle(1);
        // R7: dirty store to a line already written does not stall
        access(1, 3, 1);
        // R6: abort with several written lines and a read line
        access(1, 10, 0);
        access(0, 12, 0);
        clear_inputs(); abort = 1; step();
        idle(LINES);

        // R9: access coinciding with commit is rejected
        clear_inputs();
        acc_valid = 1; acc_is_store = 0; acc_idx = 4'd6; commit = 1; step();
        clear_inputs();
        acc_valid = 1; acc_is_store = 1; acc_idx = 4'd6; abort = 1; step();
        idle(LINES);
        // R9: commit and abort together act as abort
        access(1, 8, 0);
        clear_inputs(); commit = 1; abort = 1; step();
        idle(2);

        // R10: commit cancels a pending copy
        clear_inputs();
        acc_valid = 1; acc_is_store = 1; acc_idx = 4'd4; acc_dirty = 1;
        step(); step();
        clear_inputs(); commit = 1; step();
        idle(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule